// File: doc/BRIEF.md
# Multi-Pass Clock Replacement Victim Picker

This block tracks the recent-use state of a fixed pool of physical page frames and, when asked, names the frame to be replaced. Each frame carries a use flag, a modified flag and a small pass counter. Memory references mark a frame as used, and write references also mark it modified. A replacement request starts a circular scan. The scan pointer moves one frame per clock cycle, and it moves only while a request is being served.

As the pointer passes a frame, the block looks at that frame's use flag. A frame used since the last pass gets its use flag cleared and its pass counter zeroed, and the pointer moves on. An unused frame has its pass counter increased. A clean frame is chosen once its counter reaches one. A modified frame is given one more pass: when its counter first reaches one, the block issues a write-back request for it and moves on, and the frame is chosen when its counter reaches two. A write-back completion clears the modified flag, so the frame is then handled as clean.

The replacement path above this block issues one request at a time. It takes the chosen frame from `victim_frame` when `victim_valid` pulses, and it starts the disk transfers named by `wb_req_valid` and `wb_req_frame`.

Top module: `nclk_victim_sel`

## Requirements
- R1: When `ref_valid` is high, the frame named by `ref_frame` is marked used. If `ref_write` is also high, that frame is marked modified.
- R2: The scan pointer `hand` changes only while `busy` is high. It advances by exactly one frame (wrapping from NFRAMES-1 to 0) on every cycle of a scan. While `busy` is low it holds its value.
- R3: A frame marked used when the pointer reaches it is not chosen. Its use mark is cleared, its pass counter returns to zero, and the scan goes on to the next frame one cycle later.
- R4: An unused clean frame with its counter at zero is chosen on the first cycle in which the pointer examines it.
- R5: An unused modified frame produces one `wb_req_valid` pulse naming it on its first unused visit, and it is not chosen then. On its next unused visit it is chosen, and this holds even if no write-back has completed.
- R6: A choice is reported as a one-cycle `victim_valid` pulse with `victim_frame`. In that same cycle `busy` is low and `hand` equals victim_frame+1 modulo NFRAMES.
- R7: `wb_done_valid` clears the modified mark of `wb_done_frame`. A frame that was already passed once while modified is then chosen on its next unused visit.
- R8: A reference to the frame under examination, made in the same cycle, counts as use: that frame is not chosen and its use mark stays set for the next scan.
- R9: If every frame is marked used, the scan clears all marks on one full turn. It then chooses the frame at which the scan began, as long as that frame is clean.
- R10: After reset, `busy`, `victim_valid` and `wb_req_valid` are low, `hand` is 0, and every frame is unused, clean and at count zero. A `fault_req` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A frame is referenced this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| ref_write | input | 1 | The reference is a write, so the frame is marked modified |
| wb_done_valid | input | 1 | A write-back has finished |
| wb_done_frame | input | IDX_W | Frame whose write-back finished |
| fault_req | input | 1 | Request for a victim, accepted when idle |
| busy | output | 1 | A scan is in progress |
| hand | output | IDX_W | Current scan pointer |
| victim_valid | output | 1 | One-cycle pulse: victim chosen |
| victim_frame | output | IDX_W | Chosen frame index |
| wb_req_valid | output | 1 | One-cycle pulse: write back this frame |
| wb_req_frame | output | IDX_W | Frame to be written back |

## Verification
The assertions assume that frame indices on `ref_frame` and `wb_done_frame` are below NFRAMES. They also assume that the chosen frame is not referenced in the cycle in which it is chosen, because a reference in that cycle would count as use and the frame would not be chosen. The bench only drives indices in range. It issues references and write-back completions only while the block is idle, with one deliberate exception: a single reference placed in the exact cycle in which its frame is examined, which tests R8. Every expected victim, scan length and write-back pulse in the bench comes from a frame-state history worked out by hand from the requirements.

// File: rtl/nclk_pkg.sv
package nclk_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_st_e;
endpackage

// File: rtl/nclk_frame_slot.sv
module nclk_frame_slot #(
  parameter int DIRTY_CHANCES = 2,
  localparam int CNT_W = $clog2(DIRTY_CHANCES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exam_i,
  input  logic             evict_i,
  input  logic             ref_hit_i,
  input  logic             ref_wr_i,
  input  logic             wb_clr_i,
  output logic             use_o,
  output logic             dirty_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             use_q, use_d;
  logic             dirty_q, dirty_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en = exam_i | ref_hit_i | wb_clr_i;

  always_comb begin
    // a same-cycle reference wins over the clearing by the scan
    use_d = ref_hit_i | (use_q & ~exam_i);
    if (ref_hit_i && ref_wr_i)
      dirty_d = 1'b1;
    else if (wb_clr_i || (exam_i && evict_i))
      dirty_d = 1'b0;
    else
      dirty_d = dirty_q;
    cnt_d = cnt_q;
    if (exam_i) begin
      if (use_q || ref_hit_i || evict_i)
        cnt_d = '0;
      else
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q   <= 1'b0;
      dirty_q <= 1'b0;
      cnt_q   <= '0;
    end else if (en) begin
      use_q   <= use_d;
      dirty_q <= dirty_d;
      cnt_q   <= cnt_d;
    end
  end

  assign use_o   = use_q;
  assign dirty_o = dirty_q;
  assign cnt_o   = cnt_q;

  // R1: a reference always leaves the frame marked used
  p_ref_sets_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit_i |=> use_o);

  // R5: a stored count never reaches the dirty limit (the frame is taken first)
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o < CNT_W'(DIRTY_CHANCES));
endmodule

// File: rtl/nclk_sweep_ctrl.sv
module nclk_sweep_ctrl
  import nclk_pkg::*;
#(
  parameter int NFRAMES       = 8,
  parameter int CLEAN_CHANCES = 1,
  parameter int DIRTY_CHANCES = 2,
  localparam int IDX_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1,
  localparam int CNT_W = $clog2(DIRTY_CHANCES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fault_req,
  input  logic                     ref_valid,
  input  logic [IDX_W-1:0]         ref_frame,
  input  logic [NFRAMES-1:0]       use_vec,
  input  logic [NFRAMES-1:0]       dirty_vec,
  input  logic [NFRAMES*CNT_W-1:0] cnt_vec,
  output logic [NFRAMES-1:0]       exam_vec,
  output logic                     evict,
  output logic                     busy,
  output logic [IDX_W-1:0]         hand,
  output logic                     victim_valid,
  output logic [IDX_W-1:0]         victim_frame,
  output logic                     wb_req_valid,
  output logic [IDX_W-1:0]         wb_req_frame
);
  localparam logic [CNT_W:0] LIM_CLEAN = (CNT_W+1)'(CLEAN_CHANCES);
  localparam logic [CNT_W:0] LIM_DIRTY = (CNT_W+1)'(DIRTY_CHANCES);
  localparam logic [CNT_W:0] WB_POINT  = (CNT_W+1)'(DIRTY_CHANCES - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] h);
    return (h == IDX_W'(NFRAMES - 1)) ? '0 : h + 1'b1;
  endfunction

  sweep_st_e        st_q, st_d;
  logic [IDX_W-1:0] hand_q, hand_d;
  logic             vv_q, vv_d, wv_q, wv_d;
  logic [IDX_W-1:0] vf_q, vf_d, wf_q, wf_d;

  logic             sel_use, sel_dirty, scanning, wb_fire;
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W:0]   cnt_nx, limit;

  assign scanning  = (st_q == SW_RUN);
  assign sel_use   = use_vec[hand_q] | (ref_valid && ref_frame == hand_q);
  assign sel_dirty = dirty_vec[hand_q];
  assign sel_cnt   = cnt_vec[hand_q*CNT_W +: CNT_W];
  assign cnt_nx    = {1'b0, sel_cnt} + 1'b1;
  assign limit     = sel_dirty ? LIM_DIRTY : LIM_CLEAN;
  assign evict     = scanning && !sel_use && (cnt_nx >= limit);
  assign wb_fire   = scanning && !sel_use && sel_dirty && !evict && (cnt_nx == WB_POINT);

  for (genvar i = 0; i < NFRAMES; i++) begin : g_exam
    assign exam_vec[i] = scanning && (hand_q == IDX_W'(i));
  end

  always_comb begin
    st_d   = st_q;
    hand_d = hand_q;
    vv_d   = 1'b0;
    vf_d   = vf_q;
    wv_d   = 1'b0;
    wf_d   = wf_q;
    case (st_q)
      SW_IDLE: if (fault_req) st_d = SW_RUN;
      SW_RUN: begin
        hand_d = step(hand_q);
        if (evict) begin
          st_d = SW_IDLE;
          vv_d = 1'b1;
          vf_d = hand_q;
        end
        if (wb_fire) begin
          wv_d = 1'b1;
          wf_d = hand_q;
        end
      end
      default: st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      hand_q <= '0;
      vv_q   <= 1'b0;
      vf_q   <= '0;
      wv_q   <= 1'b0;
      wf_q   <= '0;
    end else begin
      st_q <= st_d;
      vv_q <= vv_d;
      wv_q <= wv_d;
      if (scanning) hand_q <= hand_d;
      if (vv_d)     vf_q   <= vf_d;
      if (wv_d)     wf_q   <= wf_d;
    end
  end

  assign busy         = scanning;
  assign hand         = hand_q;
  assign victim_valid = vv_q;
  assign victim_frame = vf_q;
  assign wb_req_valid = wv_q;
  assign wb_req_frame = wf_q;

  // R2: the pointer rests while idle
  p_hand_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(hand));

  // R2: one frame per scan cycle, with wrap
  p_hand_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> hand == step($past(hand)));

  // R6: a choice ends the scan, with the pointer one past the victim
  p_victim_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (!busy && hand == step(victim_frame)));
endmodule

// File: rtl/nclk_victim_sel.sv
module nclk_victim_sel #(
  parameter int NFRAMES       = 8,
  parameter int CLEAN_CHANCES = 1,
  parameter int DIRTY_CHANCES = 2,
  localparam int IDX_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1,
  localparam int CNT_W = $clog2(DIRTY_CHANCES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             ref_write,
  input  logic             wb_done_valid,
  input  logic [IDX_W-1:0] wb_done_frame,
  input  logic             fault_req,
  output logic             busy,
  output logic [IDX_W-1:0] hand,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_frame,
  output logic             wb_req_valid,
  output logic [IDX_W-1:0] wb_req_frame
);
  logic [NFRAMES-1:0]       use_vec, dirty_vec, exam_vec;
  logic [NFRAMES*CNT_W-1:0] cnt_vec;
  logic                     evict;

  for (genvar i = 0; i < NFRAMES; i++) begin : g_slot
    logic hit, clr;
    assign hit = ref_valid && (ref_frame == IDX_W'(i));
    assign clr = wb_done_valid && (wb_done_frame == IDX_W'(i));
    nclk_frame_slot #(.DIRTY_CHANCES(DIRTY_CHANCES)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .exam_i    (exam_vec[i]),
      .evict_i   (evict),
      .ref_hit_i (hit),
      .ref_wr_i  (ref_write),
      .wb_clr_i  (clr),
      .use_o     (use_vec[i]),
      .dirty_o   (dirty_vec[i]),
      .cnt_o     (cnt_vec[i*CNT_W +: CNT_W])
    );
  end

  nclk_sweep_ctrl #(
    .NFRAMES(NFRAMES), .CLEAN_CHANCES(CLEAN_CHANCES), .DIRTY_CHANCES(DIRTY_CHANCES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_req    (fault_req),
    .ref_valid    (ref_valid),
    .ref_frame    (ref_frame),
    .use_vec      (use_vec),
    .dirty_vec    (dirty_vec),
    .cnt_vec      (cnt_vec),
    .exam_vec     (exam_vec),
    .evict        (evict),
    .busy         (busy),
    .hand         (hand),
    .victim_valid (victim_valid),
    .victim_frame (victim_frame),
    .wb_req_valid (wb_req_valid),
    .wb_req_frame (wb_req_frame)
  );
endmodule

// File: tb/sim_nclk_victim_sel.sv
module sim_nclk_victim_sel;
  localparam int NF = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0, ref_write = 1'b0, wb_done_valid = 1'b0, fault_req = 1'b0;
  logic [IW-1:0] ref_frame = '0, wb_done_frame = '0;
  logic busy, victim_valid, wb_req_valid;
  logic [IW-1:0] hand, victim_frame, wb_req_frame;

  always #4 clk = ~clk; // 125 MHz

  nclk_victim_sel #(.NFRAMES(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .ref_write(ref_write), .wb_done_valid(wb_done_valid), .wb_done_frame(wb_done_frame),
    .fault_req(fault_req), .busy(busy), .hand(hand), .victim_valid(victim_valid),
    .victim_frame(victim_frame), .wb_req_valid(wb_req_valid), .wb_req_frame(wb_req_frame)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  localparam logic [1:0] OP_REF = 2'd0, OP_WBD = 2'd1, OP_FLT = 2'd2;
  typedef struct packed {
    logic [1:0] op;
    logic [1:0] fr;
    logic       wr;
    logic [1:0] ev;
    logic [3:0] ek;
    logic [1:0] ewn;
    logic [1:0] ewl;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{OP_FLT, 2'd0, 1'b0, 2'd0, 4'd1, 2'd0, 2'd0}, // R4 clean first visit
    '{OP_REF, 2'd1, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0}, // R1 read
    '{OP_REF, 2'd2, 1'b1, 2'd0, 4'd0, 2'd0, 2'd0}, // R1 write
    '{OP_FLT, 2'd0, 1'b0, 2'd3, 4'd3, 2'd0, 2'd0}, // R3 two used frames passed
    '{OP_FLT, 2'd0, 1'b0, 2'd0, 4'd1, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd1, 4'd1, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd3, 4'd2, 2'd1, 2'd2}, // R5 write-back for frame 2
    '{OP_FLT, 2'd0, 1'b0, 2'd0, 4'd1, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd1, 4'd1, 2'd0, 2'd0},
    '{OP_WBD, 2'd2, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0}, // R7 completion
    '{OP_FLT, 2'd0, 1'b0, 2'd2, 4'd1, 2'd0, 2'd0}, // R7 now clean, taken
    '{OP_REF, 2'd3, 1'b1, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_REF, 2'd0, 1'b1, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd1, 4'd3, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd2, 4'd1, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd1, 4'd3, 2'd2, 2'd0}, // R5 two write-backs
    '{OP_FLT, 2'd0, 1'b0, 2'd2, 4'd1, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd3, 4'd1, 2'd0, 2'd0}, // R5 second visit taken
    '{OP_WBD, 2'd0, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_REF, 2'd0, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_REF, 2'd1, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_REF, 2'd2, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_REF, 2'd3, 1'b0, 2'd0, 4'd0, 2'd0, 2'd0},
    '{OP_FLT, 2'd0, 1'b0, 2'd0, 4'd5, 2'd0, 2'd0}  // R9 full turn, FIFO pick
  };

  task automatic do_ref(input logic [IW-1:0] f, input logic w);
    ref_valid = 1'b1; ref_frame = f; ref_write = w;
    @(negedge clk);
    ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  task automatic do_wbd(input logic [IW-1:0] f);
    wb_done_valid = 1'b1; wb_done_frame = f;
    @(negedge clk);
    wb_done_valid = 1'b0;
  endtask

  // starts at a negedge; inj_at / dup_at name the scan edge that a stimulus precedes
  task automatic run_fault(input int inj_at, input logic [IW-1:0] inj_fr, input int dup_at,
                           output int vic, output int k, output int wbn, output int wbl);
    int n;
    n = 0; wbn = 0; wbl = 0; vic = -1;
    fault_req = 1'b1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      fault_req = 1'b0; ref_valid = 1'b0;
      if (n > 0) begin
        if (wb_req_valid) begin wbn++; wbl = int'(wb_req_frame); end
        if (victim_valid) begin vic = int'(victim_frame); break; end
      end
      if (n + 1 == inj_at) begin ref_valid = 1'b1; ref_frame = inj_fr; ref_write = 1'b0; end
      if (n + 1 == dup_at) fault_req = 1'b1;
      n++;
      if (n > 40) break;
    end
    k = n;
  endtask

  task automatic check_fault(input int ev, input int ek, input int ewn, input int ewl,
                             input int vic, input int k, input int wbn, input int wbl);
    chk("R4 victim frame", vic, ev);
    chk("R3 scan length", k, ek);
    chk("R5 write-back count", wbn, ewn);
    if (ewn > 0) chk("R5 write-back frame", wbl, ewl);
    chk("R6 hand after victim", int'(hand), (ev + 1) % NF);
    chk("R6 busy low with victim", int'(busy), 0);
  endtask

  initial begin
    int vic, k, wbn, wbl;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy at reset", int'(busy), 0);
    chk("R10 hand at reset", int'(hand), 0);
    chk("R10 victim_valid at reset", int'(victim_valid), 0);
    chk("R10 wb_req_valid at reset", int'(wb_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_REF: do_ref(VEC[i].fr, VEC[i].wr);
        OP_WBD: do_wbd(VEC[i].fr);
        default: begin
          run_fault(0, '0, 0, vic, k, wbn, wbl);
          check_fault(int'(VEC[i].ev), int'(VEC[i].ek), int'(VEC[i].ewn), int'(VEC[i].ewl),
                      vic, k, wbn, wbl);
        end
      endcase
    end

    // R8: reference lands in the cycle frame 1 is examined
    run_fault(1, 2'd1, 0, vic, k, wbn, wbl);
    check_fault(2, 2, 0, 0, vic, k, wbn, wbl);
    run_fault(0, '0, 0, vic, k, wbn, wbl);
    check_fault(3, 1, 0, 0, vic, k, wbn, wbl);
    run_fault(0, '0, 0, vic, k, wbn, wbl);
    check_fault(0, 1, 0, 0, vic, k, wbn, wbl);
    run_fault(0, '0, 0, vic, k, wbn, wbl);
    chk("R8 use mark kept, frame 1 passed", vic, 2);
    chk("R8 scan length", k, 2);

    // R10: second request during a scan is ignored
    do_ref(2'd3, 1'b0);
    do_ref(2'd0, 1'b0);
    run_fault(0, '0, 2, vic, k, wbn, wbl);
    check_fault(1, 3, 0, 0, vic, k, wbn, wbl);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R10 no scan from ignored request", int'(busy), 0);
      chk("R2 hand holds while idle", int'(hand), 2);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule